// File: doc/BRIEF.md
# Platform Reset and Sleep-Plane Controller

This block drives the active-low platform reset and three active-low power-plane control lines for a system power manager. Two asynchronous power-good inputs come in: one for core power and one for the voltage regulator. The block synchronizes both, and it holds platform reset low until both have stayed good for a programmable number of clock cycles. The same counter also stretches a one-cycle hard-reset strobe into a reset pulse of at least that length. The strobe comes from a write to the reset-control register.

The block also tracks the current power state: S0, S3, S4 or S5. A requested state code moves it between these states. A thermal-trip input forces soft-off (S5) at once. That forced state stays latched until core power-good is seen low. The three plane outputs nest: the deepest-sleep line is asserted only in soft-off, and the shallowest is asserted in every sleep state.

Top module: `plat_power_ctrl`

## Requirements
- R1: While the synchronized core power-good is low, `plat_rst_n` is low on every following cycle.
- R2: After power-good trouble ends, `plat_rst_n` rises on the HOLD_CYCLES-th rising clock edge at which both synchronized power-good signals are high and no hard-reset strobe is present. It stays low before that edge.
- R3: A hard-reset strobe drives `plat_rst_n` low at the next clock edge. It then stays low for exactly HOLD_CYCLES cycles. A new strobe during that reset restarts the count.
- R4: Power-good, regulator-good and thermal trip each pass through a SYNC_STAGES flip-flop synchronizer. An input change first affects the outputs at the (SYNC_STAGES+1)-th clock edge.
- R5: A low synchronized thermal-trip level puts the block in S5 at that clock edge: all three sleep outputs are low.
- R6: Output encoding is as follows. In S0 all sleep outputs are high. `sleep3_n` is low in S3, S4 and S5. `sleep4_n` is low in S4 and S5. `sleep5_n` is low in S5 only.
- R7: When `req_valid` is high and `req_code` (3 bits) is 0, 3, 4 or 5, the state becomes S0, S3, S4 or S5 respectively at that clock edge, unless a trip is in force.
- R8: When `req_valid` is high with any other code (1, 2, 6 or 7), the state and the sleep outputs are unchanged.
- R9: A thermal trip latches S5. While latched, requests are ignored. The latch clears on a clock edge at which synchronized power-good is low, and requests are honoured again after that.
- R10: While `rst` is high, `plat_rst_n` is low and all sleep outputs are high (S0). The trip latch is clear, and the synchronizers hold power-good low and trip inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_in | input | 1 | Core power-good, asynchronous |
| vr_good_in | input | 1 | Regulator power-good, asynchronous |
| hard_rst_req | input | 1 | One-cycle hard-reset strobe from the reset-control register |
| req_valid | input | 1 | Qualifies `req_code` |
| req_code | input | 3 | Requested state: 0=S0, 3=S3, 4=S4, 5=S5 |
| therm_trip_n | input | 1 | Active-low thermal trip, asynchronous |
| plat_rst_n | output | 1 | Active-low platform reset |
| sleep3_n | output | 1 | Active-low plane control, asserted in S3/S4/S5 |
| sleep4_n | output | 1 | Active-low plane control, asserted in S4/S5 |
| sleep5_n | output | 1 | Active-low plane control, asserted in S5 |

## Verification
A wrong stretch count shows directly on `plat_rst_n`. The release lands one or more cycles early or late relative to the HOLD_CYCLES-th good edge, so an error is visible within HOLD_CYCLES plus SYNC_STAGES cycles of power-up or of a strobe. A corrupted state register or trip latch shows on the next edge as a broken nesting of the three sleep lines, as an accepted illegal code, or as a request honoured while a trip should hold S5. A cycle-accurate bench model compares all four outputs on every cycle, so a mismatch is reported in the cycle it appears.

// File: rtl/plat_power_pkg.sv
package plat_power_pkg;

  typedef enum logic [2:0] {
    PS_S0 = 3'd0,
    PS_S3 = 3'd3,
    PS_S4 = 3'd4,
    PS_S5 = 3'd5
  } pstate_t;

  function automatic logic code_ok(input logic [2:0] c);
    return (c == 3'd0) || (c == 3'd3) || (c == 3'd4) || (c == 3'd5);
  endfunction

  function automatic logic is_sleep3(input pstate_t s);
    return (s == PS_S3) || (s == PS_S4) || (s == PS_S5);
  endfunction

  function automatic logic is_sleep4(input pstate_t s);
    return (s == PS_S4) || (s == PS_S5);
  endfunction

endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/psc_rst_stretch.sv
module psc_rst_stretch #(
  parameter int HOLD_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic pg_ok,
  input  logic vr_ok,
  input  logic hard_req,
  output logic rst_n_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          trouble;

  assign trouble = !pg_ok || !vr_ok || hard_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rst_n_o <= 1'b0;
    end else if (trouble) begin
      cnt     <= '0;
      rst_n_o <= 1'b0;
    end else if (!rst_n_o) begin
      if (cnt == LAST) rst_n_o <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/psc_state.sv
module psc_state
  import plat_power_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pg_ok,
  input  logic       trip_n,
  input  logic       req_valid,
  input  logic [2:0] req_code,
  output logic       sleep3_n,
  output logic       sleep4_n,
  output logic       sleep5_n
);
  pstate_t state, nxt;
  logic    lat, lat_nxt;

  always_comb begin
    nxt     = state;
    lat_nxt = lat;
    if (!trip_n)     lat_nxt = 1'b1;
    else if (!pg_ok) lat_nxt = 1'b0;
    if (!trip_n || lat)                        nxt = PS_S5;
    else if (req_valid && code_ok(req_code))   nxt = pstate_t'(req_code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PS_S0;
      lat      <= 1'b0;
      sleep3_n <= 1'b1;
      sleep4_n <= 1'b1;
      sleep5_n <= 1'b1;
    end else begin
      state    <= nxt;
      lat      <= lat_nxt;
      sleep3_n <= !is_sleep3(nxt);
      sleep4_n <= !is_sleep4(nxt);
      sleep5_n <= !(nxt == PS_S5);
    end
  end
endmodule

// File: rtl/plat_power_ctrl.sv
module plat_power_ctrl #(
  parameter int HOLD_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good_in,
  input  logic       vr_good_in,
  input  logic       hard_rst_req,
  input  logic       req_valid,
  input  logic [2:0] req_code,
  input  logic       therm_trip_n,
  output logic       plat_rst_n,
  output logic       sleep3_n,
  output logic       sleep4_n,
  output logic       sleep5_n
);
  localparam int NA = 3;
  localparam logic [NA-1:0] A_RST = 3'b100;

  logic [NA-1:0] a_raw, a_syn;
  logic          pg_s, vr_s, trip_s_n;

  assign a_raw = {therm_trip_n, vr_good_in, pwr_good_in};

  for (genvar g = 0; g < NA; g++) begin : g_sync
    psc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(A_RST[g])) u_sync (
      .clk(clk), .rst(rst), .d(a_raw[g]), .q(a_syn[g])
    );
  end

  assign pg_s     = a_syn[0];
  assign vr_s     = a_syn[1];
  assign trip_s_n = a_syn[2];

  psc_rst_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
    .clk(clk), .rst(rst), .pg_ok(pg_s), .vr_ok(vr_s),
    .hard_req(hard_rst_req), .rst_n_o(plat_rst_n)
  );

  psc_state u_state (
    .clk(clk), .rst(rst), .pg_ok(pg_s), .trip_n(trip_s_n),
    .req_valid(req_valid), .req_code(req_code),
    .sleep3_n(sleep3_n), .sleep4_n(sleep4_n), .sleep5_n(sleep5_n)
  );
endmodule

// File: rtl/plat_power_ctrl_chk.sv
module plat_power_ctrl_chk #(
  parameter int HOLD_CYCLES = 1000
) (
  input logic       clk,
  input logic       rst,
  input logic       pg_sync,
  input logic       trip_sync_n,
  input logic       req_valid,
  input logic [2:0] req_code,
  input logic       plat_rst_n,
  input logic       sleep3_n,
  input logic       sleep4_n,
  input logic       sleep5_n
);
  localparam int LW = $clog2(HOLD_CYCLES + 2);
  logic [LW-1:0] low_run;
  logic          prev_rst_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run    <= '0;
      prev_rst_n <= 1'b0;
    end else begin
      prev_rst_n <= plat_rst_n;
      if (plat_rst_n) low_run <= '0;
      else if (low_run != LW'(HOLD_CYCLES)) low_run <= low_run + 1'b1;
    end
  end

  AST_RST_HELD_PG_LOW: assert property (@(posedge clk) disable iff (rst)
    !pg_sync |=> !plat_rst_n); // R1

  AST_MIN_RESET_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (plat_rst_n && !prev_rst_n) |-> (low_run >= LW'(HOLD_CYCLES))); // R3

  AST_TRIP_FORCES_S5: assert property (@(posedge clk) disable iff (rst)
    !trip_sync_n |=> (!sleep5_n && !sleep4_n && !sleep3_n)); // R5

  AST_PLANE_NEST4: assert property (@(posedge clk) disable iff (rst)
    !sleep4_n |-> !sleep3_n); // R6

  AST_PLANE_NEST5: assert property (@(posedge clk) disable iff (rst)
    !sleep5_n |-> !sleep4_n); // R6

  AST_BAD_CODE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && trip_sync_n && !(req_code inside {3'd0, 3'd3, 3'd4, 3'd5}))
      |=> ($stable(sleep3_n) && $stable(sleep4_n) && $stable(sleep5_n))); // R8
endmodule

bind plat_power_ctrl plat_power_ctrl_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .pg_sync(pg_s), .trip_sync_n(trip_s_n),
  .req_valid(req_valid), .req_code(req_code), .plat_rst_n(plat_rst_n),
  .sleep3_n(sleep3_n), .sleep4_n(sleep4_n), .sleep5_n(sleep5_n)
);

// File: tb/plat_power_ctrl_bench.sv
module plat_power_ctrl_bench;
  localparam int H = 12;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg = 1'b0, vr = 1'b0, hreq = 1'b0, rv = 1'b0, trn = 1'b1;
  logic [2:0] rc = 3'd0;
  logic prn, s3n, s4n, s5n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  plat_power_ctrl #(.HOLD_CYCLES(H), .SYNC_STAGES(S)) u_plat_power_ctrl (
    .clk(clk), .rst(rst), .pwr_good_in(pg), .vr_good_in(vr),
    .hard_rst_req(hreq), .req_valid(rv), .req_code(rc), .therm_trip_n(trn),
    .plat_rst_n(prn), .sleep3_n(s3n), .sleep4_n(s4n), .sleep5_n(s5n)
  );

  // Reference model built from the requirements
  logic [S-1:0] mp, mv, mt;
  logic m_rst_n, m_lat;
  int   m_cnt;
  logic [2:0] m_st;

  function automatic logic valid_code(input logic [2:0] c);
    return c == 3'd0 || c == 3'd3 || c == 3'd4 || c == 3'd5;
  endfunction
  function automatic logic [2:0] exp_planes(input logic [2:0] st);
    return {!(st == 3'd3 || st == 3'd4 || st == 3'd5), !(st == 3'd4 || st == 3'd5), !(st == 3'd5)};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mp <= '0; mv <= '0; mt <= '1;
      m_rst_n <= 1'b0; m_cnt <= 0; m_lat <= 1'b0; m_st <= 3'd0;
    end else begin
      mp <= {mp[S-2:0], pg}; mv <= {mv[S-2:0], vr}; mt <= {mt[S-2:0], trn};
      if (!mp[S-1] || !mv[S-1] || hreq) begin m_cnt <= 0; m_rst_n <= 1'b0; end
      else if (!m_rst_n) begin
        if (m_cnt == H-1) m_rst_n <= 1'b1; else m_cnt <= m_cnt + 1;
      end
      if (!mt[S-1]) m_lat <= 1'b1; else if (!mp[S-1]) m_lat <= 1'b0;
      if (!mt[S-1] || m_lat) m_st <= 3'd5;
      else if (rv && valid_code(rc)) m_st <= rc;
    end
  end

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {rst_n,s3n,s4n,s5n} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  string tag = "R10";
  task automatic tick();
    @(posedge clk); @(negedge clk);
    check(tag, {prn, s3n, s4n, s5n}, {m_rst_n, exp_planes(m_st)});
  endtask

  task automatic req(input logic [2:0] c);
    rv = 1'b1; rc = c; tick(); rv = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired (R2 progress) actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed1234));
    @(negedge clk);
    tag = "R10"; tick(); tick();
    check("R10 reset state", {prn, s3n, s4n, s5n}, 4'b0111);
    rst = 1'b0;

    // Power-up timing: release at edge S+H after both goods rise
    tag = "R2"; pg = 1'b1; vr = 1'b1; n = 0;
    while (prn == 1'b0 && n < 200) begin tick(); n++; end
    check("R2 R4 release edge", 4'(n), 4'(S + H));

    // Hard-reset strobe width
    tag = "R3"; hreq = 1'b1; tick(); hreq = 1'b0; n = 1;
    while (prn == 1'b0 && n < 200) begin tick(); n++; end
    check("R3 stretch width", 4'(n - 1), 4'(H));
    // Restart while active
    hreq = 1'b1; tick(); hreq = 1'b0; repeat (4) tick();
    hreq = 1'b1; tick(); hreq = 1'b0; n = 6;
    while (prn == 1'b0 && n < 200) begin tick(); n++; end
    check("R3 restart width", 5'(n - 1), 5'(5 + H));

    // State codes
    tag = "R7"; req(3'd3); check("R6 R7 S3", {s3n, s4n, s5n}, 3'b011);
    req(3'd4); check("R6 R7 S4", {s3n, s4n, s5n}, 3'b001);
    req(3'd5); check("R6 R7 S5", {s3n, s4n, s5n}, 3'b000);
    req(3'd0); check("R6 R7 S0", {s3n, s4n, s5n}, 3'b111);
    req(3'd3);
    tag = "R8"; req(3'd6); check("R8 code 6 ignored", {s3n, s4n, s5n}, 3'b011);
    req(3'd1); check("R8 code 1 ignored", {s3n, s4n, s5n}, 3'b011);

    // Thermal trip
    tag = "R5"; trn = 1'b0; tick(); trn = 1'b1; tick();
    check("R4 trip not yet", {s3n, s4n, s5n}, 3'b011);
    tick(); check("R5 trip S5", {s3n, s4n, s5n}, 3'b000);
    tag = "R9"; repeat (3) tick(); req(3'd0);
    check("R9 latched S5", {s3n, s4n, s5n}, 3'b000);
    pg = 1'b0; repeat (4) tick();
    check("R1 reset while pg low", 1'(prn), 1'b0);
    pg = 1'b1; repeat (S + H + 2) tick(); req(3'd0);
    check("R9 latch cleared", {s3n, s4n, s5n}, 3'b111);

    // Constrained random mix
    tag = "R2 R6 random";
    for (int i = 0; i < 4000; i++) begin
      if (pg) begin if ($urandom % 300 == 0) pg = 1'b0; end
      else if ($urandom % 10 == 0) pg = 1'b1;
      if (vr) begin if ($urandom % 400 == 0) vr = 1'b0; end
      else if ($urandom % 8 == 0) vr = 1'b1;
      trn  = ($urandom % 500 != 0);
      hreq = ($urandom % 120 == 0);
      rv   = ($urandom % 6 == 0);
      rc   = 3'($urandom % 8);
      tick();
    end
    done = 1'b1;
    finish_run();
  end
endmodule